// File: doc/BRIEF.md
# Multi-Lane DLL Bring-Up Sequencer

This block walks the delay-locked loops of a memory PHY through their power-up sequence: one master lane first, then a group of byte-lane slaves together. A single start pulse captures a 32-bit packed phase word and a bus-width select. The master lane receives a 6-bit phase and each slave lane receives a 4-bit phase from that word. Each lane is then driven through three timed steps on its active-high disable line and its active-low reset line. The step lengths are counted in microseconds, using a tick derived from the `CLK_MHZ` parameter.

The controller is a state machine with eight named states. IDLE is the state after reset. M_HOLD, M_FREE and M_RUN are the master's steps. S_HOLD, S_FREE and S_RUN are the slaves' steps. DONE is the finished state. Its transitions are:
- *accept*: start seen in IDLE or DONE, which moves to M_HOLD.
- *step*: timer expiry, which moves M_HOLD to M_FREE to M_RUN to S_HOLD to S_FREE to S_RUN.
- *finish*: expiry in S_RUN, which moves to DONE.

Every other input leaves the state where it is. In 32-bit mode four slave lanes are used. In 16-bit mode only two are used, and the remaining lanes are kept disabled and in reset.

Top module: `dll_bringup_seq`

## Requirements
- R1: After reset every lane has disable=1 and reset_n=0, all phase outputs are 0, and busy and done are both 0.
- R2: `master_phase` equals bits 21:16 of the phase word captured at the accepted start.
- R3: Slave lane k (k = 1..4) receives phase bits [4k-1:4k-4] of the captured word on `slave_phase[4k-1:4k-4]`.
- R4: With `wide_bus`=1, slave lanes 1..4 are active. With `wide_bus`=0, only slave lanes 1..2 are active. An inactive lane keeps disable=1, reset_n=0 and phase 0 throughout.
- R5: Each lane passes through three steps in order:
  - hold: disable=1, reset_n=0, for `SETTLE_US` (2) µs;
  - free: disable=0, reset_n=0, for `RELEASE_US` (22) µs;
  - run: disable=0, reset_n=1, for `RUN_US` (22) µs.
  A step of N µs lasts exactly N·`CLK_MHZ` clock cycles, and a lane never shows reset_n=1 together with disable=1.
- R6: The slave lanes leave hold only after the master has finished its run step, which is 46 µs after the accepting edge. All active slaves step together, and the master stays in run afterwards.
- R7: `busy` is 1 from the accepting edge for 92·`CLK_MHZ` cycles. `done` then rises as busy falls. The two are never 1 together.
- R8: A start that arrives while busy is ignored, together with the phase word and width presented with it.
- R9: `done` stays 1 until the next start. A start in DONE restarts the full sequence with the newly presented phase word and width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, `CLK_MHZ` MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only in IDLE or DONE |
| wide_bus | input | 1 | 1 = 32-bit bus (4 slaves), 0 = 16-bit bus (2 slaves) |
| phase_cfg | input | 32 | Packed phase word |
| master_phase | output | 6 | Phase field of the master lane |
| slave_phase | output | 4·MAX_SLAVES | Phase fields of the slave lanes, lane 1 in the low nibble |
| lane_dis | output | MAX_SLAVES+1 | Active-high disable per lane, bit 0 is the master |
| lane_rst_n | output | MAX_SLAVES+1 | Active-low reset per lane, bit 0 is the master |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, level held until the next start |

## Verification
The hardest situation to reach is a second start, with a different phase word and width, landing in the middle of a running sequence. The captured values must survive it, and the step timing must not be disturbed. The bench sweeps both widths across a set of phase words and runs every sequence back to back, so each start after the first one is a restart from DONE. In half of the runs it injects a conflicting start at a cycle offset that varies from run to run. Those offsets fall in all six steps, including the cycles just before a step boundary. Every cycle of every run is compared against expected values computed from the segment boundaries in microseconds.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_M_HOLD = 3'd1,
        ST_M_FREE = 3'd2,
        ST_M_RUN  = 3'd3,
        ST_S_HOLD = 3'd4,
        ST_S_FREE = 3'd5,
        ST_S_RUN  = 3'd6,
        ST_DONE   = 3'd7
    } seq_state_t;

    // drive condition of one lane: {disable, reset_n}
    typedef enum logic [1:0] {
        LN_HELD = 2'b10,
        LN_FREE = 2'b00,
        LN_RUN  = 2'b01
    } lane_cond_t;

    localparam int unsigned PHASE_W      = 32;
    localparam int unsigned MASTER_PH_W  = 6;
    localparam int unsigned MASTER_PH_LO = 16;
    localparam int unsigned SLAVE_PH_W   = 4;
    localparam int unsigned US_W         = 8;

endpackage

// File: rtl/dll_us_timer.sv
module dll_us_timer #(
    parameter int unsigned CLK_MHZ = 4,
    parameter int unsigned US_W    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic [US_W-1:0] n_us,
    output logic            expire
);
    localparam int unsigned PRE_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_MHZ - 1);

    logic [PRE_W-1:0] pre_q;
    logic [US_W-1:0]  left_q;
    logic             us_tick;

    assign us_tick = (pre_q == PRE_LAST);
    assign expire  = us_tick && (left_q == US_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            left_q <= '0;
        end else if (arm) begin
            pre_q  <= '0;
            left_q <= n_us;
        end else begin
            pre_q <= us_tick ? '0 : pre_q + 1'b1;
            if (us_tick && left_q != '0)
                left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/dll_phase_map.sv
module dll_phase_map
    import dll_seq_pkg::*;
#(
    parameter int unsigned MAX_SLAVES    = 4,
    parameter int unsigned NARROW_SLAVES = 2
) (
    input  logic [PHASE_W-1:0]               cfg,
    input  logic                             wide,
    output logic [MASTER_PH_W-1:0]           m_phase,
    output logic [MAX_SLAVES*SLAVE_PH_W-1:0] s_phase,
    output logic [MAX_SLAVES-1:0]            s_active
);
    assign m_phase = cfg[MASTER_PH_LO +: MASTER_PH_W];

    for (genvar k = 0; k < MAX_SLAVES; k++) begin : g_slave
        if (k < NARROW_SLAVES) begin : g_always
            assign s_active[k] = 1'b1;
        end else begin : g_wide_only
            assign s_active[k] = wide;
        end
        assign s_phase[k*SLAVE_PH_W +: SLAVE_PH_W] =
            s_active[k] ? cfg[k*SLAVE_PH_W +: SLAVE_PH_W] : '0;
    end
endmodule

// File: rtl/dll_seq_fsm.sv
module dll_seq_fsm
    import dll_seq_pkg::*;
#(
    parameter int unsigned SETTLE_US  = 2,
    parameter int unsigned RELEASE_US = 22,
    parameter int unsigned RUN_US     = 22
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            expire,
    output logic            accept,
    output logic            arm,
    output logic [US_W-1:0] n_us,
    output lane_cond_t      m_cond,
    output lane_cond_t      s_cond,
    output logic            busy,
    output logic            done
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (start) begin
                state_d = ST_M_HOLD;
                accept  = 1'b1;
            end
            ST_M_HOLD: if (expire) state_d = ST_M_FREE;
            ST_M_FREE: if (expire) state_d = ST_M_RUN;
            ST_M_RUN:  if (expire) state_d = ST_S_HOLD;
            ST_S_HOLD: if (expire) state_d = ST_S_FREE;
            ST_S_FREE: if (expire) state_d = ST_S_RUN;
            ST_S_RUN:  if (expire) state_d = ST_DONE;
        endcase
        arm = (state_d != state_q) && (state_d != ST_DONE);
        unique case (state_d)
            ST_M_HOLD, ST_S_HOLD: n_us = US_W'(SETTLE_US);
            ST_M_FREE, ST_S_FREE: n_us = US_W'(RELEASE_US);
            default:              n_us = US_W'(RUN_US);
        endcase
    end

    always_comb begin
        m_cond = LN_HELD;
        s_cond = LN_HELD;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_M_HOLD: m_cond = LN_HELD;
            ST_M_FREE: m_cond = LN_FREE;
            ST_M_RUN:  m_cond = LN_RUN;
            ST_S_HOLD: m_cond = LN_RUN;
            ST_S_FREE: begin m_cond = LN_RUN; s_cond = LN_FREE; end
            ST_S_RUN:  begin m_cond = LN_RUN; s_cond = LN_RUN;  end
            ST_DONE: begin
                m_cond = LN_RUN;
                s_cond = LN_RUN;
                busy   = 1'b0;
                done   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq
    import dll_seq_pkg::*;
#(
    parameter int unsigned CLK_MHZ       = 4,
    parameter int unsigned MAX_SLAVES    = 4,
    parameter int unsigned NARROW_SLAVES = 2,
    parameter int unsigned SETTLE_US     = 2,
    parameter int unsigned RELEASE_US    = 22,
    parameter int unsigned RUN_US        = 22
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic                             wide_bus,
    input  logic [31:0]                      phase_cfg,
    output logic [5:0]                       master_phase,
    output logic [MAX_SLAVES*4-1:0]          slave_phase,
    output logic [MAX_SLAVES:0]              lane_dis,
    output logic [MAX_SLAVES:0]              lane_rst_n,
    output logic                             busy,
    output logic                             done
);
    logic [PHASE_W-1:0]    cfg_q;
    logic                  wide_q;
    logic                  accept, arm, expire;
    logic [US_W-1:0]       n_us;
    lane_cond_t            m_cond, s_cond;
    logic [MAX_SLAVES-1:0] s_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            wide_q <= 1'b0;
        end else if (accept) begin
            cfg_q  <= phase_cfg;
            wide_q <= wide_bus;
        end
    end

    dll_seq_fsm #(
        .SETTLE_US (SETTLE_US),
        .RELEASE_US(RELEASE_US),
        .RUN_US    (RUN_US)
    ) i_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .expire(expire),
        .accept(accept),
        .arm   (arm),
        .n_us  (n_us),
        .m_cond(m_cond),
        .s_cond(s_cond),
        .busy  (busy),
        .done  (done)
    );

    dll_us_timer #(
        .CLK_MHZ(CLK_MHZ),
        .US_W   (US_W)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .n_us  (n_us),
        .expire(expire)
    );

    dll_phase_map #(
        .MAX_SLAVES   (MAX_SLAVES),
        .NARROW_SLAVES(NARROW_SLAVES)
    ) i_map (
        .cfg     (cfg_q),
        .wide    (wide_q),
        .m_phase (master_phase),
        .s_phase (slave_phase),
        .s_active(s_active)
    );

    assign lane_dis[0]   = m_cond[1];
    assign lane_rst_n[0] = m_cond[0];

    for (genvar k = 0; k < MAX_SLAVES; k++) begin : g_lane
        assign lane_dis[k+1]   = s_active[k] ? s_cond[1] : 1'b1;
        assign lane_rst_n[k+1] = s_active[k] ? s_cond[0] : 1'b0;
    end
endmodule

// File: rtl/dll_bringup_seq_chk.sv
module dll_bringup_seq_chk #(
    parameter int unsigned MAX_SLAVES = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic [5:0]              master_phase,
    input logic [MAX_SLAVES*4-1:0] slave_phase,
    input logic [MAX_SLAVES:0]     lane_dis,
    input logic [MAX_SLAVES:0]     lane_rst_n,
    input logic                    busy,
    input logic                    done
);
    for (genvar i = 0; i <= MAX_SLAVES; i++) begin : g_ln
        a_r5_no_release_while_disabled: assert property (
            @(posedge clk) disable iff (!rst_n)
            lane_rst_n[i] |-> !lane_dis[i]);
    end

    a_r6_master_before_slaves: assert property (
        @(posedge clk) disable iff (!rst_n)
        (|(~lane_dis[MAX_SLAVES:1])) |-> (lane_rst_n[0] && !lane_dis[0]));

    a_r7_busy_done_exclusive: assert property (
        @(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r8_start_ignored_busy: assert property (
        @(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(master_phase) && $stable(slave_phase)));

    a_r9_done_holds: assert property (
        @(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

bind dll_bringup_seq dll_bringup_seq_chk #(.MAX_SLAVES(MAX_SLAVES)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .master_phase(master_phase),
    .slave_phase (slave_phase),
    .lane_dis    (lane_dis),
    .lane_rst_n  (lane_rst_n),
    .busy        (busy),
    .done        (done)
);

// File: tb/test_dll_bringup_seq.sv
module test_dll_bringup_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MHZ        = 2;
    localparam int NS         = 4;
    localparam int B_MFREE    = 2 * MHZ;
    localparam int B_MRUN     = 24 * MHZ;
    localparam int B_SHOLD    = 46 * MHZ;
    localparam int B_SFREE    = 48 * MHZ;
    localparam int B_SRUN     = 70 * MHZ;
    localparam int B_DONE     = 92 * MHZ;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide_bus = 1'b0;
    logic [31:0] phase_cfg = '0;
    logic [5:0]  master_phase;
    logic [15:0] slave_phase;
    logic [4:0]  lane_dis, lane_rst_n;
    logic        busy, done;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dll_bringup_seq #(.CLK_MHZ(MHZ), .MAX_SLAVES(NS)) i_dll_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_bus(wide_bus),
        .phase_cfg(phase_cfg), .master_phase(master_phase),
        .slave_phase(slave_phase), .lane_dis(lane_dis),
        .lane_rst_n(lane_rst_n), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp_v, $time);
        end
    endtask

    // {dis, rst_n} pair for a step window starting at edge index b0
    function automatic logic [1:0] step_cond(input int j, input int b0);
        if (j < b0 + 2 * MHZ)       return 2'b10;
        else if (j < b0 + 24 * MHZ) return 2'b00;
        else                        return 2'b01;
    endfunction

    // j: edges since the accepting edge (0 = that edge)
    task automatic check_cycle(input int j, input logic [31:0] cfg, input logic wide);
        logic [15:0] exp_sp;
        logic [4:0]  exp_dis, exp_rn;
        logic [1:0]  mc, sc;
        mc = step_cond(j, 0);
        sc = (j < B_SHOLD) ? 2'b10 : step_cond(j, B_SHOLD);
        exp_dis[0] = mc[1];
        exp_rn[0]  = mc[0];
        for (int k = 0; k < NS; k++) begin
            logic act;
            act = (k < 2) || wide;
            exp_sp[k*4 +: 4] = act ? cfg[k*4 +: 4] : 4'h0;
            exp_dis[k+1] = act ? sc[1] : 1'b1;
            exp_rn[k+1]  = act ? sc[0] : 1'b0;
        end
        chk("R2 master phase", 32'(master_phase), 32'(cfg[21:16]));
        chk(wide ? "R3 slave phase" : "R4 unused lane phase", 32'(slave_phase), 32'(exp_sp));
        chk(j < B_SHOLD ? "R5 master step / R4 lane ctl" : "R6 slave step", 32'({lane_dis, lane_rst_n}),
            32'({exp_dis, exp_rn}));
        chk("R7 busy/done", 32'({busy, done}), 32'({j < B_DONE, j >= B_DONE}));
    endtask

    // inject_at < 0: no mid-run start (R8)
    task automatic run_seq(input logic [31:0] cfg, input logic wide, input int inject_at);
        @(negedge clk);
        start = 1'b1; phase_cfg = cfg; wide_bus = wide;
        @(negedge clk);
        start = 1'b0; phase_cfg = ~cfg; wide_bus = ~wide;
        for (int j = 0; j < B_DONE + 6; j++) begin
            check_cycle(j, cfg, wide);
            if (j == inject_at) begin
                start = 1'b1; phase_cfg = cfg ^ 32'h5A5A_A5A5; wide_bus = ~wide;
            end
            @(negedge clk);
            start = 1'b0;
        end
        // R9: done holds while idle
        chk("R9 done held", 32'(done), 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset lane ctl", 32'({lane_dis, lane_rst_n}), 32'({5'b11111, 5'b00000}));
        chk("R1 reset phases", 32'({master_phase, slave_phase}), 32'd0);
        chk("R1 reset busy/done", 32'({busy, done}), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 idle lane ctl", 32'({lane_dis, lane_rst_n}), 32'({5'b11111, 5'b00000}));
        chk("R1 idle busy/done", 32'({busy, done}), 32'd0);

        run_seq(32'h0000_0000, 1'b1, -1);
        run_seq(32'hFFFF_FFFF, 1'b0, -1);
        run_seq(32'h003F_A5C3, 1'b1, B_MFREE - 1);
        run_seq(32'h0015_1234, 1'b0, B_SFREE - 1);
        for (int i = 0; i < 12; i++) begin
            logic [31:0] p;
            p = (32'h9E37_79B9 * 32'(i + 1)) ^ (32'h1 << (i * 3 % 32));
            run_seq(p, i[0], (i % 2 == 1) ? (i * 23) % B_DONE : -1);
        end
        run_seq(32'h0012_3456, 1'b1, B_DONE - 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule